// File: doc/BRIEF.md
# DTMF Digit Validator and Serial Framer

This block sits behind a dual-tone detector. Each cycle it receives a tone-present flag and two 2-bit indices: one for the lower tone group and one for the upper tone group. It waits until one pairing has been held long enough to count as a real key press. It then turns the key into a 4-bit code and adds a nibble that makes the code and the check sum to zero modulo 16. The result goes out on a single serial line as a ten-bit word at 1200 baud, while an active-low valid line marks the digit.

After a digit is accepted, the block ignores the tone until the line has been silent for a pause interval. A key held down therefore yields exactly one word. The valid line goes high again once the pause ends, and a new digit then needs a full stability interval.

Power-down acts as a synchronous clear. It forces both outputs high and drops any frame in flight. Every time constant comes from the clock-rate parameter: one bit lasts `CLK_HZ/1200` cycles, the stability window is 40 ms and the pause is 20 ms.

Top module: `dtmf_rx_framer`

## Requirements
- R1: Row index 0..3 selects 697/770/852/941 Hz and column index 0..3 selects 1209/1336/1477/1633 Hz. Row 0 gives codes 1,2,3,13; row 1 gives 4,5,6,14; row 2 gives 7,8,9,15; row 3 gives 11,10,12,0 (keys *,0,#,D).
- R2: The check nibble is (16 − code) mod 16, so code 0 carries check 0.
- R3: The word on `ser_out` is a 0 start bit, then code bits 0..3, then check bits 0..3, then a 1 stop bit. Each bit lasts `CLK_HZ/1200` cycles, and the start bit begins on the same edge where `valid_n` falls.
- R4: `valid_n` falls on the clock edge that samples the tone with the same indices for the `CLK_HZ/1000*40`-th consecutive time.
- R5: A change of either index, or a single cycle without tone, during the stability window restarts the count from that point.
- R6: While a digit is held, further tone produces no second word, and `valid_n` stays low.
- R7: `valid_n` rises on the edge after the `CLK_HZ/1000*20`-th consecutive tone-free sample, provided the word has finished. A shorter gap followed by tone keeps the digit held. After the rise, a fresh full stability window is needed.
- R8: `ser_out` is high whenever no word is being sent.
- R9: Reset, and `power_down` sampled high, drive `ser_out` and `valid_n` high on the next edge. Any word in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| power_down | input | 1 | Synchronous clear; holds outputs high |
| tone_vld | input | 1 | Detector reports a valid tone pair |
| row_idx | input | 2 | Lower-group tone index |
| col_idx | input | 2 | Upper-group tone index |
| ser_out | output | 1 | Serial data, idles high |
| valid_n | output | 1 | Active-low digit valid |

## Verification
All sixteen index pairs are sent, and the decoded serial word is compared with a key table written out in the bench. This separates mapping errors from check-nibble errors and from bit-order errors. Three other patterns are applied. A tone that switches indices or drops for one cycle just before the window ends tells a restarting timer from one that keeps counting. A held key with a short gap tells a proper pause from a re-trigger. A power-down in the middle of a word shows that the clear cuts the word off. A behavioural model also checks both outputs on every clock.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    typedef logic [3:0] nib_t;

    typedef struct packed {
        logic [1:0] row;
        logic [1:0] col;
    } key_t;

    // Bits that follow the start bit, LSB shifted out first.
    typedef struct packed {
        logic stop;
        nib_t chk;
        nib_t code;
    } tail_t;

    typedef enum logic {
        CTL_ARMED = 1'b0,
        CTL_HELD  = 1'b1
    } ctl_e;

    localparam int TAIL_BITS = $bits(tail_t);

    function automatic nib_t key_code(key_t k);
        nib_t c;
        if (k.col == 2'd3)
            c = 4'd13 + {2'b00, k.row};
        else if (k.row != 2'd3)
            c = ({2'b00, k.row} * 4'd3) + {2'b00, k.col} + 4'd1;
        else begin
            case (k.col)
                2'd0:    c = 4'd11;
                2'd1:    c = 4'd10;
                default: c = 4'd12;
            endcase
        end
        return c;
    endfunction

    function automatic nib_t key_check(nib_t c);
        return 4'd0 - c;
    endfunction

    function automatic tail_t make_tail(nib_t c);
        tail_t t;
        t.stop = 1'b1;
        t.chk  = key_check(c);
        t.code = c;
        return t;
    endfunction

endpackage

// File: rtl/dtmf_stable.sv
module dtmf_stable
    import dtmf_pkg::*;
#(
    parameter int HOLD_CYC = 480
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic tone,
    input  key_t key,
    output logic accept
);
    localparam int SW = $clog2(HOLD_CYC + 1);

    logic [SW-1:0] cnt;
    key_t          key_q;
    logic          same;

    assign same   = (cnt != '0) && (key == key_q);
    assign accept = en && tone && same && (cnt == SW'(HOLD_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || !en) begin
            cnt   <= '0;
            key_q <= '0;
        end else if (!tone) begin
            cnt <= '0;
        end else if (!same) begin
            cnt   <= SW'(1);
            key_q <= key;
        end else if (cnt != SW'(HOLD_CYC)) begin
            cnt <= cnt + SW'(1);
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= SW'(HOLD_CYC));

    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && tone && cnt != '0 && key != key_q) |=> (cnt == SW'(1)));

endmodule

// File: rtl/dtmf_pause.sv
module dtmf_pause #(
    parameter int GAP_CYC = 240
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic tone,
    output logic gap_done
);
    localparam int GW = $clog2(GAP_CYC + 1);

    logic [GW-1:0] cnt;

    assign gap_done = (cnt == GW'(GAP_CYC));

    always_ff @(posedge clk) begin
        if (rst || clr || !en || tone)
            cnt <= '0;
        else if (!gap_done)
            cnt <= cnt + GW'(1);
    end

    assert_gap_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= GW'(GAP_CYC));

    assert_tone_clears_R7: assert property (@(posedge clk) disable iff (rst)
        tone |=> (cnt == '0));

endmodule

// File: rtl/dtmf_serializer.sv
module dtmf_serializer
    import dtmf_pkg::*;
#(
    parameter int BIT_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic load,
    input  nib_t code,
    output logic sdo,
    output logic busy
);
    localparam int BW = $clog2(BIT_CYC + 1);
    localparam int LW = $clog2(TAIL_BITS + 1);

    logic [BW-1:0]        baud;
    logic [LW-1:0]        left;
    logic [TAIL_BITS-1:0] rest;
    logic                 sdo_q;
    logic                 busy_q;

    assign sdo  = sdo_q;
    assign busy = busy_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sdo_q  <= 1'b1;
            busy_q <= 1'b0;
            baud   <= '0;
            left   <= '0;
            rest   <= '0;
        end else if (load) begin
            sdo_q  <= 1'b0;
            busy_q <= 1'b1;
            rest   <= make_tail(code);
            left   <= LW'(TAIL_BITS);
            baud   <= BW'(BIT_CYC - 1);
        end else if (busy_q) begin
            if (baud != '0) begin
                baud <= baud - BW'(1);
            end else if (left == '0) begin
                busy_q <= 1'b0;
            end else begin
                sdo_q <= rest[0];
                rest  <= {1'b0, rest[TAIL_BITS-1:1]};
                left  <= left - LW'(1);
                baud  <= BW'(BIT_CYC - 1);
            end
        end
    end

    assert_load_idle_R6: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy_q);

    assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> sdo_q);

endmodule

// File: rtl/dtmf_rx_framer.sv
module dtmf_rx_framer
    import dtmf_pkg::*;
#(
    parameter int CLK_HZ  = 2_457_600,
    parameter int BAUD    = 1200,
    parameter int HOLD_MS = 40,
    parameter int GAP_MS  = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       power_down,
    input  logic       tone_vld,
    input  logic [1:0] row_idx,
    input  logic [1:0] col_idx,
    output logic       ser_out,
    output logic       valid_n
);
    localparam int BIT_CYC  = CLK_HZ / BAUD;
    localparam int HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;
    localparam int GAP_CYC  = (CLK_HZ / 1000) * GAP_MS;

    ctl_e state;
    key_t key;
    logic accept;
    logic gap_done;
    logic busy;
    logic release_dig;
    logic dv_q;

    assign key.row     = row_idx;
    assign key.col     = col_idx;
    assign release_dig = (state == CTL_HELD) && gap_done && !busy;
    assign valid_n     = dv_q;

    dtmf_stable #(.HOLD_CYC(HOLD_CYC)) u_stable (
        .clk    (clk),
        .rst    (rst),
        .clr    (power_down),
        .en     (state == CTL_ARMED),
        .tone   (tone_vld),
        .key    (key),
        .accept (accept)
    );

    dtmf_pause #(.GAP_CYC(GAP_CYC)) u_pause (
        .clk      (clk),
        .rst      (rst),
        .clr      (power_down),
        .en       (state == CTL_HELD),
        .tone     (tone_vld),
        .gap_done (gap_done)
    );

    dtmf_serializer #(.BIT_CYC(BIT_CYC)) u_ser (
        .clk  (clk),
        .rst  (rst),
        .clr  (power_down),
        .load (accept),
        .code (key_code(key)),
        .sdo  (ser_out),
        .busy (busy)
    );

    always_ff @(posedge clk) begin
        if (rst || power_down) begin
            state <= CTL_ARMED;
            dv_q  <= 1'b1;
        end else if (accept) begin
            state <= CTL_HELD;
            dv_q  <= 1'b0;
        end else if (release_dig) begin
            state <= CTL_ARMED;
            dv_q  <= 1'b1;
        end
    end

    assert_pd_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        power_down |=> (valid_n && ser_out));

    assert_start_with_dv_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(valid_n) |-> !ser_out);

    assert_line_idle_R8: assert property (@(posedge clk) disable iff (rst)
        valid_n |-> ser_out);

endmodule

// File: tb/dtmf_rx_framer_tb.sv
module dtmf_rx_framer_tb;
    localparam int CLK_HZ = 12000;
    localparam int BIT    = CLK_HZ / 1200;
    localparam int HOLD   = (CLK_HZ / 1000) * 40;
    localparam int GAP    = (CLK_HZ / 1000) * 20;
    localparam int FRAME  = 10 * BIT;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       power_down = 1'b0;
    logic       tone_vld = 1'b0;
    logic [1:0] row_idx = 2'd0;
    logic [1:0] col_idx = 2'd0;
    logic       ser_out;
    logic       valid_n;

    int  errs = 0;
    int  checks = 0;
    bit  finished = 0;
    bit  cmp_on = 0;

    always #5 clk = ~clk;

    dtmf_rx_framer #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst(rst), .power_down(power_down), .tone_vld(tone_vld),
        .row_idx(row_idx), .col_idx(col_idx), .ser_out(ser_out), .valid_n(valid_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Key legend by row then column; codes derived from the legend character.
    function automatic int exp_code(input int r, input int c);
        string keys;
        byte   ch;
        keys = "123A456B789C*0#D";
        ch = keys[r*4 + c];
        if (ch >= "1" && ch <= "9") return ch - "0";
        if (ch == "0") return 10;
        if (ch == "*") return 11;
        if (ch == "#") return 12;
        if (ch == "D") return 0;
        return 13 + (ch - "A");
    endfunction

    // Behavioural reference, advanced on every rising edge.
    bit     m_armed = 1, m_dv = 1, m_sdo = 1;
    int     m_stab = 0, m_pcnt = 0, m_key = 0;
    bit     m_q[$];

    always @(posedge clk) begin
        int  k;
        bit  busy;
        k = row_idx * 4 + col_idx;
        if (rst || power_down) begin
            m_armed = 1; m_dv = 1; m_stab = 0; m_pcnt = 0; m_q.delete();
        end else begin
            busy = (m_q.size() > 0);
            if (m_armed) begin
                if (tone_vld && m_stab > 0 && k == m_key && m_stab == HOLD - 1) begin
                    int code, cs;
                    code = exp_code(row_idx, col_idx);
                    cs = (16 - code) % 16;
                    for (int b = 0; b < 10; b++) begin
                        bit v;
                        if (b == 0) v = 0;
                        else if (b <= 4) v = code[b-1];
                        else if (b <= 8) v = cs[b-5];
                        else v = 1;
                        for (int j = 0; j < BIT; j++) m_q.push_back(v);
                    end
                    m_armed = 0; m_dv = 0; m_pcnt = 0; m_stab = 0;
                end else if (!tone_vld) m_stab = 0;
                else if (m_stab == 0 || k != m_key) begin m_stab = 1; m_key = k; end
                else if (m_stab < HOLD) m_stab++;
            end else begin
                if (m_pcnt == GAP && !busy) begin
                    m_armed = 1; m_dv = 1; m_pcnt = 0;
                end else if (tone_vld) m_pcnt = 0;
                else if (m_pcnt < GAP) m_pcnt++;
            end
        end
        m_sdo = (m_q.size() > 0) ? m_q.pop_front() : 1'b1;
    end

    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk(ser_out === m_sdo, "R3", "model ser_out", int'(ser_out), int'(m_sdo));
            chk(valid_n === m_dv, "R4", "model valid_n", int'(valid_n), int'(m_dv));
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Applies a key, checks the accept time and the serial word; tone stays on.
    task automatic run_digit(input int r, input int c);
        int n, code, cs, got_code, got_cs;
        bit bits[10];
        row_idx = 2'(r); col_idx = 2'(c); tone_vld = 1'b1;
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (valid_n && n < 4 * HOLD);
        chk(n == HOLD, "R4", "cycles to accept", n, HOLD);
        for (int i = 0; i < FRAME; i++) begin
            if (i % BIT == BIT / 2) bits[i / BIT] = ser_out;
            @(negedge clk);
        end
        code = exp_code(r, c);
        cs = (16 - code) % 16;
        got_code = 0; got_cs = 0;
        for (int b = 0; b < 4; b++) begin
            got_code |= int'(bits[1+b]) << b;
            got_cs   |= int'(bits[5+b]) << b;
        end
        chk(got_code == code, "R1", $sformatf("code row%0d col%0d", r, c), got_code, code);
        chk(got_cs == cs, "R2", "check nibble", got_cs, cs);
        chk(bits[0] == 0 && bits[9] == 1, "R3", "start/stop", {bits[0], bits[9]}, 1);
    endtask

    task automatic hold_quiet(input int n);
        bit ok = 1;
        for (int i = 0; i < n; i++) begin
            if (valid_n !== 1'b0 || ser_out !== 1'b1) ok = 0;
            @(negedge clk);
        end
        chk(ok, "R6", "held tone gives no second word", int'(ok), 1);
        chk(ser_out === 1'b1, "R8", "line idle high after word", int'(ser_out), 1);
    endtask

    task automatic pause_check();
        int n = 0;
        tone_vld = 1'b0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!valid_n && n < 4 * GAP);
        chk(n == GAP + 1, "R7", "cycles to release", n, GAP + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(valid_n === 1'b1 && ser_out === 1'b1, "R9", "reset state",
            {valid_n, ser_out}, 3);
        rst = 1'b0;
        cmp_on = 1;
        cycles(5);

        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                run_digit(r, c);
                hold_quiet(FRAME);
                pause_check();
                cycles(3);
            end

        // R5: index change late in the window restarts the count
        row_idx = 2'd1; col_idx = 2'd1; tone_vld = 1'b1;
        cycles(HOLD - 5);
        chk(valid_n === 1'b1, "R5", "no accept before window", int'(valid_n), 1);
        run_digit(2, 3);
        pause_check();

        // R5: one tone-free cycle restarts the count
        row_idx = 2'd0; col_idx = 2'd2; tone_vld = 1'b1;
        cycles(HOLD - 5);
        tone_vld = 1'b0;
        cycles(1);
        run_digit(0, 2);

        // R7: a short gap keeps the digit held, then a full pause re-arms
        tone_vld = 1'b0;
        cycles(GAP / 2);
        tone_vld = 1'b1;
        hold_quiet(2 * HOLD);
        chk(valid_n === 1'b0, "R7", "short gap keeps digit", int'(valid_n), 0);
        pause_check();

        // R9: power-down in the middle of a word
        row_idx = 2'd3; col_idx = 2'd1; tone_vld = 1'b1;
        while (valid_n) @(negedge clk);
        cycles(3 * BIT);
        power_down = 1'b1;
        cycles(1);
        chk(valid_n === 1'b1 && ser_out === 1'b1, "R9", "power-down outputs",
            {valid_n, ser_out}, 3);
        cycles(2 * FRAME);
        chk(valid_n === 1'b1 && ser_out === 1'b1, "R9", "power-down held",
            {valid_n, ser_out}, 3);
        power_down = 1'b0; tone_vld = 1'b0;
        cycles(FRAME);
        chk(ser_out === 1'b1, "R8", "idle after power-down", int'(ser_out), 1);
        run_digit(3, 3);
        pause_check();
        cycles(5);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errs++; checks++;
            $display("FAIL R4 watchdog expired: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule